// File: doc/BRIEF.md
# Truth-Table Logic and Adder Unit

This block is a combinational 16-bit arithmetic and logic datapath. Every bit position holds two small programmable function cells, one on an upper plane and one on a lower plane. Each cell reads the A and B bits of its own position and returns one bit of a 4-bit truth-table code. Both planes feed a single adder with a selectable carry input. All arithmetic and logic operations come from choosing two truth-table codes and a carry source for each operation code. Logic results pass through the adder unchanged because the lower plane is then forced to zero.

Equality is detected without a zero detector. The upper plane produces A XNOR B, and the carry input is tied to 1. The sum carries out of the top bit only when every XNOR bit is 1, that is, only when A equals B. After a plain subtraction a separate flag reports the signed A < B. The flag is built from the two operand signs and the result sign. An active-low output enable blanks the result to zero and leaves both flags valid, so compare-only operations are possible.

Top module: `mla_alu_core`

## Requirements
- R1: Op code 2 (AND) gives result A & B and carry_out 0. A plane cell selects its truth-table code bit 3 - {b,a}, so code 0001 is AND.
- R2: Op codes 3 (OR), 4 (XOR) and 5 (NOR) give A | B, A ^ B and ~(A | B). carry_out is 0 for every op code from 2 to 5.
- R3: Op code 0 (ADD) gives (A + B) mod 2^16, and carry_out is bit 16 of the full sum. The carry flag input has no effect.
- R4: Op code 8 (ADD with carry) gives A + B + carry_flag. carry_out is the carry out of bit 15.
- R5: Op code 1 (SUB) gives A + ~B + 1 mod 2^16. carry_out is 1 exactly when A >= B unsigned, so 0 means a borrow occurred. The carry flag has no effect.
- R6: Op code 9 (SUB with borrow) gives A + ~B + carry_flag mod 2^16, with carry_out taken from the top of that sum.
- R7: Op code 10 (EQ) sets carry_out to 1 exactly when A == B. The result is (~(A ^ B) + 1) mod 2^16, which is 0 when the operands are equal.
- R8: For op code 1, less_than equals the signed comparison A < B. If the operand signs differ it follows A's sign bit; otherwise it follows bit 15 of the result. For every other op code less_than is 0.
- R9: While out_en_n_i is 1, result_o is all zeros, and carry_out_o and less_than_o keep the values they would have with the output enabled.
- R10: Op codes 6, 7 and 11 to 15 give result 0, carry_out 0 and less_than 0.
- R11: The carry flag changes no output for any op code other than 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code: bits 2:0 base operation, bit 3 variant |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| carry_flag_i | input | 1 | Carry flag used by the two carry-chained variants |
| out_en_n_i | input | 1 | Active-low result enable |
| result_o | output | 16 | Operation result, zero while disabled |
| carry_out_o | output | 1 | Adder carry out, equality flag for EQ |
| less_than_o | output | 1 | Signed A < B, valid for plain subtraction |

## Verification
The unit holds no state, so a wrong truth-table code, carry source or plane routing shows at the ports as soon as the operands settle. The fault appears in the same evaluation in which its operation code is applied. A bit swapped inside a plane cell only shows for operand pairs that reach that select value, so each operation is run on many random operand pairs. A broken group carry in the adder only shows when a carry has to cross a group boundary. The EQ runs therefore include every single-bit difference, and the add runs include all-ones patterns. A fault in the flag path shows only on the flags, so the blanked-output runs compare both flags against the enabled case.

// File: rtl/mla_pkg.sv
package mla_pkg;

    typedef logic [3:0] tt_code_t;

    // Truth-table codes: bit 3 is chosen for select {b,a}=00, bit 0 for 11
    localparam tt_code_t TT_ZERO   = 4'b0000;
    localparam tt_code_t TT_AND    = 4'b0001;
    localparam tt_code_t TT_PASS_B = 4'b0011;
    localparam tt_code_t TT_PASS_A = 4'b0101;
    localparam tt_code_t TT_XOR    = 4'b0110;
    localparam tt_code_t TT_OR     = 4'b0111;
    localparam tt_code_t TT_NOR    = 4'b1000;
    localparam tt_code_t TT_XNOR   = 4'b1001;
    localparam tt_code_t TT_NOT_B  = 4'b1100;

    typedef enum logic [2:0] {
        BOP_ADD = 3'd0,
        BOP_SUB = 3'd1,
        BOP_AND = 3'd2,
        BOP_OR  = 3'd3,
        BOP_XOR = 3'd4,
        BOP_NOR = 3'd5,
        BOP_SLL = 3'd6,
        BOP_SRL = 3'd7
    } base_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_src_e;

    typedef struct packed {
        tt_code_t u_code;
        tt_code_t v_code;
        cin_src_e cin_src;
        logic     sel_lt;
        logic     valid;
    } ctl_t;

    function automatic logic tt_eval(input tt_code_t code, input logic a, input logic b);
        return code[{~b, ~a}];
    endfunction

    function automatic ctl_t decode_op(input logic [3:0] op);
        ctl_t     c;
        base_op_e base;
        logic     variant;
        base    = base_op_e'(op[2:0]);
        variant = op[3];
        c = '{u_code: TT_ZERO, v_code: TT_ZERO, cin_src: CIN_ZERO, sel_lt: 1'b0, valid: 1'b0};
        case (base)
            BOP_ADD: begin
                c.u_code  = TT_PASS_A;
                c.v_code  = TT_PASS_B;
                c.cin_src = variant ? CIN_FLAG : CIN_ZERO;
                c.valid   = 1'b1;
            end
            BOP_SUB: begin
                c.u_code  = TT_PASS_A;
                c.v_code  = TT_NOT_B;
                c.cin_src = variant ? CIN_FLAG : CIN_ONE;
                c.sel_lt  = ~variant;
                c.valid   = 1'b1;
            end
            BOP_AND: begin
                c.u_code  = variant ? TT_XNOR : TT_AND;
                c.cin_src = variant ? CIN_ONE : CIN_ZERO;
                c.valid   = 1'b1;
            end
            BOP_OR: begin
                c.u_code = variant ? TT_ZERO : TT_OR;
                c.valid  = ~variant;
            end
            BOP_XOR: begin
                c.u_code = variant ? TT_ZERO : TT_XOR;
                c.valid  = ~variant;
            end
            BOP_NOR: begin
                c.u_code = variant ? TT_ZERO : TT_NOR;
                c.valid  = ~variant;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mla_decode.sv
module mla_decode
    import mla_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic       carry_flag_i,
    output tt_code_t   u_code_o,
    output tt_code_t   v_code_o,
    output logic       cin_o,
    output logic       sel_lt_o,
    output logic       valid_o
);
    ctl_t ctl;

    always_comb begin
        ctl      = decode_op(op_i);
        u_code_o = ctl.u_code;
        v_code_o = ctl.v_code;
        sel_lt_o = ctl.sel_lt;
        valid_o  = ctl.valid;
        case (ctl.cin_src)
            CIN_ONE:  cin_o = 1'b1;
            CIN_FLAG: cin_o = carry_flag_i;
            default:  cin_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mla_tt_plane.sv
module mla_tt_plane
    import mla_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  tt_code_t          code_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
        assign y_o[i] = tt_eval(code_i, a_i[i], b_i[i]);
    end
endmodule

// File: rtl/mla_adder.sv
module mla_adder #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned GROUP_W = 4
) (
    input  logic [DATA_W-1:0] u_i,
    input  logic [DATA_W-1:0] v_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);
    localparam int unsigned N_GROUPS = DATA_W / GROUP_W;

    logic [N_GROUPS:0] carry;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [GROUP_W:0] part;
        assign part = {1'b0, u_i[g*GROUP_W +: GROUP_W]}
                    + {1'b0, v_i[g*GROUP_W +: GROUP_W]}
                    + {{GROUP_W{1'b0}}, carry[g]};
        assign sum_o[g*GROUP_W +: GROUP_W] = part[GROUP_W-1:0];
        assign carry[g+1] = part[GROUP_W];
    end

    assign cout_o = carry[N_GROUPS];
endmodule

// File: rtl/mla_flags.sv
module mla_flags #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] sum_i,
    input  logic              cout_i,
    input  logic              a_msb_i,
    input  logic              b_msb_i,
    input  logic              sel_lt_i,
    input  logic              valid_i,
    input  logic              out_en_n_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_out_o,
    output logic              less_than_o
);
    logic signs_differ;
    logic lt_raw;

    always_comb begin
        signs_differ = a_msb_i ^ b_msb_i;
        lt_raw       = signs_differ ? a_msb_i : sum_i[DATA_W-1];
        less_than_o  = sel_lt_i & lt_raw;
        carry_out_o  = valid_i & cout_i;
        result_o     = (valid_i && !out_en_n_i) ? sum_i : '0;
    end
endmodule

// File: rtl/mla_alu_core.sv
module mla_alu_core
    import mla_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned GROUP_W = 4
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_flag_i,
    input  logic              out_en_n_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_out_o,
    output logic              less_than_o
);
    tt_code_t          u_code;
    tt_code_t          v_code;
    logic              cin;
    logic              sel_lt;
    logic              valid;
    logic [DATA_W-1:0] u_plane;
    logic [DATA_W-1:0] v_plane;
    logic [DATA_W-1:0] sum;
    logic              cout;

    mla_decode i_decode (
        .op_i         (op_i),
        .carry_flag_i (carry_flag_i),
        .u_code_o     (u_code),
        .v_code_o     (v_code),
        .cin_o        (cin),
        .sel_lt_o     (sel_lt),
        .valid_o      (valid)
    );

    mla_tt_plane #(.DATA_W(DATA_W)) i_plane_u (
        .code_i (u_code),
        .a_i    (a_i),
        .b_i    (b_i),
        .y_o    (u_plane)
    );

    mla_tt_plane #(.DATA_W(DATA_W)) i_plane_v (
        .code_i (v_code),
        .a_i    (a_i),
        .b_i    (b_i),
        .y_o    (v_plane)
    );

    mla_adder #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) i_adder (
        .u_i    (u_plane),
        .v_i    (v_plane),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    mla_flags #(.DATA_W(DATA_W)) i_flags (
        .sum_i       (sum),
        .cout_i      (cout),
        .a_msb_i     (a_i[DATA_W-1]),
        .b_msb_i     (b_i[DATA_W-1]),
        .sel_lt_i    (sel_lt),
        .valid_i     (valid),
        .out_en_n_i  (out_en_n_i),
        .result_o    (result_o),
        .carry_out_o (carry_out_o),
        .less_than_o (less_than_o)
    );
endmodule

// File: rtl/mla_alu_core_chk.sv
module mla_alu_core_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              carry_flag_i,
    input logic              out_en_n_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_out_o,
    input logic              less_than_o
);
    logic [DATA_W-1:0] addc_ref;

    always_comb begin
        addc_ref = a_i + b_i + {{(DATA_W-1){1'b0}}, carry_flag_i};

        if (out_en_n_i)
            a_r9_blank_result: assert (result_o == '0);

        if (op_i >= 4'd2 && op_i <= 4'd5)
            a_r2_logic_no_carry: assert (!carry_out_o);

        if (op_i == 4'd10)
            a_r7_eq_carry: assert (carry_out_o == (a_i == b_i));

        if (op_i == 4'd1)
            a_r5_sub_no_borrow: assert (carry_out_o == (a_i >= b_i));

        if (op_i == 4'd1)
            a_r8_signed_lt: assert (less_than_o == ($signed(a_i) < $signed(b_i)));
        else
            a_r8_lt_idle: assert (!less_than_o);

        if (op_i == 4'd6 || op_i == 4'd7 || op_i >= 4'd11)
            a_r10_unhandled_zero: assert (result_o == '0 && !carry_out_o);

        if (op_i == 4'd8 && !out_en_n_i)
            a_r4_addc_sum: assert (result_o == addc_ref);
    end
endmodule

bind mla_alu_core mla_alu_core_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_mla_alu_core.sv
module test_mla_alu_core;

    logic        clk = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cf = 1'b0;
    logic        oe_n = 1'b0;
    logic [15:0] result;
    logic        carry_out;
    logic        less_than;

    int n_total = 0;
    int n_bad   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mla_alu_core i_mla_alu_core (
        .op_i         (op),
        .a_i          (a),
        .b_i          (b),
        .carry_flag_i (cf),
        .out_en_n_i   (oe_n),
        .result_o     (result),
        .carry_out_o  (carry_out),
        .less_than_o  (less_than)
    );

    // Reference: {less_than, carry_out, result}
    function automatic logic [17:0] model(input logic [3:0] o, input logic [15:0] x,
                                          input logic [15:0] y, input logic c, input logic en_n);
        logic [16:0] full;
        logic [15:0] r;
        logic        co;
        logic        lt;
        r = '0; co = 1'b0; lt = 1'b0;
        case (o)
            4'd0:  begin full = {1'b0, x} + {1'b0, y}; r = full[15:0]; co = full[16]; end
            4'd8:  begin full = {1'b0, x} + {1'b0, y} + {16'd0, c}; r = full[15:0]; co = full[16]; end
            4'd1:  begin r = x - y; co = (x >= y); lt = ($signed(x) < $signed(y)); end
            4'd9:  begin full = {1'b0, x} + {1'b0, ~y} + {16'd0, c}; r = full[15:0]; co = full[16]; end
            4'd2:  r = x & y;
            4'd3:  r = x | y;
            4'd4:  r = x ^ y;
            4'd5:  r = ~(x | y);
            4'd10: begin r = ~(x ^ y) + 16'd1; co = (x == y); end
            default: ;
        endcase
        if (en_n) r = '0;
        return {lt, co, r};
    endfunction

    task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                         input logic c, input logic en_n);
        @(posedge clk);
        op = o; a = x; b = y; cf = c; oe_n = en_n;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h cf=%0d: got lt/c/res=%0d/%0d/%h exp=%0d/%0d/%h",
                     tag, op, a, b, cf, got[17], got[16], got[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic run_one(input string tag, input logic [3:0] o, input logic [15:0] x,
                           input logic [15:0] y, input logic c, input logic en_n);
        apply(o, x, y, c, en_n);
        chk(tag, {less_than, carry_out, result}, model(o, x, y, c, en_n));
    endtask

    task automatic t_idle_state;
        run_one("R3 idle zero operands", 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_logic;
        for (int i = 0; i < 24; i++) begin
            run_one("R1 and", 4'd2, 16'($urandom), 16'($urandom), 1'b0, 1'b0);
            run_one("R2 or",  4'd3, 16'($urandom), 16'($urandom), 1'b1, 1'b0);
            run_one("R2 xor", 4'd4, 16'($urandom), 16'($urandom), 1'b0, 1'b0);
            run_one("R2 nor", 4'd5, 16'($urandom), 16'($urandom), 1'b1, 1'b0);
        end
        run_one("R1 and all ones", 4'd2, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        run_one("R2 nor zeros",    4'd5, 16'h0000, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_add;
        for (int i = 0; i < 24; i++) begin
            run_one("R3 add",  4'd0, 16'($urandom), 16'($urandom), 1'($urandom), 1'b0);
            run_one("R4 addc", 4'd8, 16'($urandom), 16'($urandom), 1'($urandom), 1'b0);
        end
        run_one("R3 add ripple",     4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
        run_one("R4 addc full ripple", 4'd8, 16'hFFFF, 16'h0000, 1'b1, 1'b0);
        run_one("R4 addc group edge", 4'd8, 16'h00FF, 16'h0000, 1'b1, 1'b0);
    endtask

    task automatic t_sub;
        for (int i = 0; i < 24; i++) begin
            run_one("R5 sub",  4'd1, 16'($urandom), 16'($urandom), 1'($urandom), 1'b0);
            run_one("R6 subb", 4'd9, 16'($urandom), 16'($urandom), 1'($urandom), 1'b0);
        end
        run_one("R5 sub equal",    4'd1, 16'h1234, 16'h1234, 1'b0, 1'b0);
        run_one("R5 sub borrow",   4'd1, 16'h0000, 16'h0001, 1'b1, 1'b0);
        run_one("R6 subb cf0 eq",  4'd9, 16'h4000, 16'h4000, 1'b0, 1'b0);
        run_one("R6 subb cf1 eq",  4'd9, 16'h4000, 16'h4000, 1'b1, 1'b0);
    endtask

    task automatic t_eq;
        logic [15:0] v;
        for (int i = 0; i < 8; i++) begin
            v = 16'($urandom);
            run_one("R7 eq same", 4'd10, v, v, 1'b0, 1'b0);
        end
        for (int k = 0; k < 16; k++) begin
            v = 16'($urandom);
            run_one("R7 eq one bit differs", 4'd10, v, v ^ (16'h1 << k), 1'b0, 1'b0);
        end
        for (int i = 0; i < 8; i++)
            run_one("R7 eq random", 4'd10, 16'($urandom), 16'($urandom), 1'b1, 1'b0);
    endtask

    task automatic t_less_than;
        run_one("R8 neg vs pos", 4'd1, 16'h8000, 16'h7FFF, 1'b0, 1'b0);
        run_one("R8 pos vs neg", 4'd1, 16'h7FFF, 16'h8000, 1'b0, 1'b0);
        run_one("R8 both neg",   4'd1, 16'hFFFE, 16'hFFFF, 1'b0, 1'b0);
        run_one("R8 both pos",   4'd1, 16'h0005, 16'h0003, 1'b0, 1'b0);
        run_one("R8 idle on subb", 4'd9, 16'h8000, 16'h7FFF, 1'b1, 1'b0);
        run_one("R8 idle on add",  4'd0, 16'h8000, 16'h7FFF, 1'b0, 1'b0);
    endtask

    task automatic t_blank;
        logic [15:0] x;
        logic [15:0] y;
        logic [1:0]  flags_on;
        for (int i = 0; i < 12; i++) begin
            x = 16'($urandom);
            y = (i % 3 == 0) ? x : 16'($urandom);
            apply(4'd1, x, y, 1'b0, 1'b0);
            flags_on = {less_than, carry_out};
            run_one("R9 sub blanked", 4'd1, x, y, 1'b0, 1'b1);
            chk("R9 flags match enabled", {less_than, carry_out, 16'h0}, {flags_on, 16'h0});
            run_one("R9 eq blanked", 4'd10, x, y, 1'b0, 1'b1);
        end
    endtask

    task automatic t_unhandled;
        logic [3:0] codes [7] = '{4'd6, 4'd7, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
        foreach (codes[j]) begin
            run_one("R10 unhandled", codes[j], 16'hFFFF, 16'h0001, 1'b1, 1'b0);
            run_one("R10 unhandled rnd", codes[j], 16'($urandom), 16'($urandom), 1'b0, 1'b0);
        end
    endtask

    task automatic t_flag_ignored;
        logic [15:0] x;
        logic [15:0] y;
        logic [17:0] first;
        logic [3:0]  ops [6] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd10};
        foreach (ops[j]) begin
            x = 16'($urandom);
            y = 16'($urandom);
            apply(ops[j], x, y, 1'b0, 1'b0);
            first = {less_than, carry_out, result};
            apply(ops[j], x, y, 1'b1, 1'b0);
            chk("R11 carry flag ignored", {less_than, carry_out, result}, first);
        end
    endtask

    initial begin
        t_idle_state();
        t_logic();
        t_add();
        t_sub();
        t_eq();
        t_less_than();
        t_blank();
        t_unhandled();
        t_flag_ignored();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog: got cycles=%0d exp below 50000", cycles);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule